// File: doc/BRIEF.md
# Byte-Serial Command Write Receiver

This block sits at the receiving end of a narrow command bus. A master sends a register write as a short burst of bytes, one per clock. A strobe marks the first byte. The receiver rebuilds a 14-bit register address and a 32-bit data word from the burst. It checks the address against a base and mask of its own. When the address falls in its window, it raises a write pulse for one clock, with the address and data beside it.

The number of bytes the receiver collects, `NBYTES` (1 to 6), is set at elaboration. Byte positions it does not collect are treated as zero. A short command can therefore write a small value, or select an address, using fewer bus cycles. The byte order on the bus is fixed:

| Position | Byte |
|---|---|
| 0 | address low byte |
| 1 | address high byte |
| 2 to 5 | data, least significant byte first |

A strobe may follow the last byte of a command with no gap. A strobe that arrives before a command is complete abandons that partial command.

Top module: `cmdbus_byte_rx`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its capture state. After that edge `wr_pulse` is 0 and `wr_addr` and `wr_data` are 0. A strobe seen during reset starts no capture.
- R2: The bytes are mapped by position. Bus byte 0 becomes `wr_addr[7:0]` and byte 1 bits 5:0 become `wr_addr[13:8]`. Bytes 2, 3, 4 and 5 become `wr_data[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`.
- R3: Bits 7:6 of the address high byte have no effect on `wr_addr` or on the window match.
- R4: Every byte position at or above `NBYTES` reads as zero in `wr_addr`/`wr_data`, whatever the bus carries in that cycle.
- R5: If the strobe is in cycle s and no strobe or reset interrupts the command, `wr_pulse` is high in cycle s+NBYTES. For `NBYTES`=1 that is the cycle right after the strobe.
- R6: `wr_pulse` is raised only when ((address XOR `BASE`) AND `MASK`) is zero. A completed command that fails this test produces no pulse and leaves the outputs unchanged.
- R7: `wr_addr` and `wr_data` change only in a cycle where `wr_pulse` is high, or after a reset. They hold their value otherwise.
- R8: A new strobe in the cycle right after the last byte of a command is accepted. With `NBYTES`=1, strobes on consecutive cycles each produce their own write.
- R9: A strobe that arrives before `NBYTES` bytes of the current command are collected drops that command, and no pulse is produced for it. The new strobe starts a fresh capture.
- R10: Bus bytes seen while no capture is in progress are ignored.
- R11: `wr_pulse` lasts one cycle per command. With `NBYTES` > 1 it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_stb | input | 1 | Start strobe, high with the address low byte |
| bus_byte | input | 8 | Serial command byte |
| wr_pulse | output | 1 | One-cycle write strobe for a matched command |
| wr_addr | output | 14 | Register address of the last matched write |
| wr_data | output | 32 | Data of the last matched write |

## Verification
Two functions can act in the same cycle. One is the completion of a command, which latches the last byte and schedules a pulse. The other is the capture of a new strobe, which must clear the byte buffer and restart the count. The bench provokes this overlap by driving a strobe right after the last byte, strobes on every cycle, and strobes that cut a command short. It does this against a six-byte receiver and a three-byte receiver sharing one bus, so the same stream completes in one and is cut off in the other. Expected pulse cycles and held output values are worked out per frame from the strobe positions and reset cycles. Outputs are compared every cycle.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 6;
    localparam int ADDR_W    = 14;
    localparam int DATA_W    = 32;
    localparam int FRAME_W   = MAX_BYTES * BYTE_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef logic [BYTE_W-1:0] bus_byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // Pull the address out of an assembled frame: low byte plus six bits of the high byte
    function automatic addr_t frame_addr(input logic [FRAME_W-1:0] f);
        return {f[BYTE_W +: ADDR_W-BYTE_W], f[0 +: BYTE_W]};
    endfunction

    function automatic data_t frame_data(input logic [FRAME_W-1:0] f);
        return f[2*BYTE_W +: DATA_W];
    endfunction
endpackage

// File: rtl/cmdrx_collect.sv
module cmdrx_collect
    import cmdrx_pkg::*;
#(
    parameter int NBYTES = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  bus_byte_t           din,
    output logic                done,
    output logic [FRAME_W-1:0]  frame
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NBYTES - 1);

    typedef struct packed {
        logic                            busy;
        logic [CNT_W-1:0]                pos;
        logic [MAX_BYTES-1:0][BYTE_W-1:0] bytes;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        done  = 1'b0;
        if (stb) begin
            // a strobe always restarts, clearing every unsent position to zero
            col_d.bytes    = '0;
            col_d.bytes[0] = din;
            col_d.pos      = CNT_W'(1);
            if (NBYTES == 1) begin
                done       = 1'b1;
                col_d.busy = 1'b0;
            end else begin
                col_d.busy = 1'b1;
            end
        end else if (col_q.busy) begin
            col_d.bytes[col_q.pos] = din;
            col_d.pos              = col_q.pos + 1'b1;
            if (col_q.pos == LAST_POS) begin
                done       = 1'b1;
                col_d.busy = 1'b0;
            end
        end
        frame = col_d.bytes;
    end

    always_ff @(posedge clk) begin
        if (rst) col_q <= '0;
        else     col_q <= col_d;
    end
endmodule

// File: rtl/cmdrx_match.sv
module cmdrx_match
    import cmdrx_pkg::*;
#(
    parameter addr_t BASE = '0,
    parameter addr_t MASK = '0
) (
    input  addr_t addr,
    output logic  hit
);
    assign hit = ((addr ^ BASE) & MASK) == '0;
endmodule

// File: rtl/cmdbus_byte_rx.sv
module cmdbus_byte_rx
    import cmdrx_pkg::*;
#(
    parameter int    NBYTES = 6,
    parameter addr_t BASE   = 14'h0A00,
    parameter addr_t MASK   = 14'h3F00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_stb,
    input  logic [7:0]  bus_byte,
    output logic        wr_pulse,
    output logic [13:0] wr_addr,
    output logic [31:0] wr_data
);
    typedef struct packed {
        logic  pulse;
        addr_t addr;
        data_t data;
    } out_t;

    logic               cmd_done;
    logic [FRAME_W-1:0] cmd_frame;
    addr_t              cmd_addr;
    logic               cmd_hit;
    out_t               out_d, out_q;

    cmdrx_collect #(.NBYTES(NBYTES)) u_collect (
        .clk   (clk),
        .rst   (rst),
        .stb   (bus_stb),
        .din   (bus_byte),
        .done  (cmd_done),
        .frame (cmd_frame)
    );

    assign cmd_addr = frame_addr(cmd_frame);

    cmdrx_match #(.BASE(BASE), .MASK(MASK)) u_match (
        .addr (cmd_addr),
        .hit  (cmd_hit)
    );

    always_comb begin
        out_d       = out_q;
        out_d.pulse = cmd_done && cmd_hit;
        if (out_d.pulse) begin
            out_d.addr = cmd_addr;
            out_d.data = frame_data(cmd_frame);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign wr_pulse = out_q.pulse;
    assign wr_addr  = out_q.addr;
    assign wr_data  = out_q.data;
endmodule

// File: rtl/cmdbus_byte_rx_chk.sv
module cmdbus_byte_rx_chk #(
    parameter int          NBYTES = 6,
    parameter logic [13:0] BASE   = 14'h0A00,
    parameter logic [13:0] MASK   = 14'h3F00
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_stb,
    input logic [7:0]  bus_byte,
    input logic        wr_pulse,
    input logic [13:0] wr_addr,
    input logic [31:0] wr_data
);
    localparam int KEPT_BITS = NBYTES * 8;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wr_pulse && wr_addr == '0 && wr_data == '0)); // R1

    AST_WINDOW_HIT: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> (((wr_addr ^ BASE) & MASK) == '0)); // R6

    AST_PULSE_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(bus_stb, NBYTES)); // R5

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> (({wr_data, 2'b00, wr_addr} >> KEPT_BITS) == 48'd0)); // R4

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (wr_pulse || rst || ($stable(wr_addr) && $stable(wr_data)))); // R7

    generate
        if (NBYTES > 1) begin : g_multi
            AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
                wr_pulse |=> !wr_pulse); // R11
        end
    endgenerate
endmodule

bind cmdbus_byte_rx cmdbus_byte_rx_chk #(
    .NBYTES (NBYTES),
    .BASE   (BASE),
    .MASK   (MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_stb  (bus_stb),
    .bus_byte (bus_byte),
    .wr_pulse (wr_pulse),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/cmdbus_byte_rx_test.sv
`timescale 1ns/1ps
module cmdbus_byte_rx_test;
    localparam int T = 2400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_stb = 1'b0;
    logic [7:0]  bus_byte = 8'h00;
    logic        p6, p3;
    logic [13:0] a6, a3;
    logic [31:0] d6, d3;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic        stb_a [T];
    logic        rst_a [T];
    logic [7:0]  byte_a[T];
    logic        exp_p [2][T];
    logic [13:0] exp_a [2][T];
    logic [31:0] exp_d [2][T];

    always #4 clk = ~clk;

    cmdbus_byte_rx #(.NBYTES(6), .BASE(14'h0A00), .MASK(14'h3F00)) uut (
        .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_byte(bus_byte),
        .wr_pulse(p6), .wr_addr(a6), .wr_data(d6));

    cmdbus_byte_rx #(.NBYTES(3), .BASE(14'h0000), .MASK(14'h3000)) uut_short (
        .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_byte(bus_byte),
        .wr_pulse(p3), .wr_addr(a3), .wr_data(d3));

    task automatic chk(input bit ok, input string tag, input int t,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, t, act, exp);
        end
    endtask

    // Expected frame word for a capture starting at s, with positions >= n zero (R2 R3 R4)
    function automatic logic [47:0] exp_word(input int s, input int n);
        logic [47:0] w = '0;
        for (int j = 0; j < 6; j++)
            if (j < n && s + j < T) w[j*8 +: 8] = byte_a[s+j];
        return w;
    endfunction

    task automatic fill_exp(input int k, input int n, input logic [13:0] base,
                            input logic [13:0] mask);
        logic [13:0] ha = '0;
        logic [31:0] hd = '0;
        for (int t = 0; t < T; t++) begin
            exp_p[k][t] = 1'b0;
            exp_a[k][t] = '0;
            exp_d[k][t] = '0;
        end
        for (int s = 0; s < T; s++) begin
            if (stb_a[s]) begin
                int nx = T;
                bit ok = 1'b1;
                logic [47:0] w;
                logic [13:0] ad;
                for (int q = T - 1; q > s; q--) if (stb_a[q]) nx = q;
                if (nx - s < n) ok = 1'b0;                  // R9 cut short
                for (int j = 0; j < n; j++) if (s + j < T && rst_a[s+j]) ok = 1'b0;
                w  = exp_word(s, n);
                ad = {w[13:8], w[7:0]};
                if (ok && (((ad ^ base) & mask) == 14'h0) && s + n < T) begin
                    exp_p[k][s+n] = 1'b1;
                    exp_a[k][s+n] = ad;
                    exp_d[k][s+n] = w[47:16];
                end
            end
        end
        for (int t = 0; t < T; t++) begin
            if (t > 0 && rst_a[t-1]) begin ha = '0; hd = '0; end
            if (exp_p[k][t]) begin ha = exp_a[k][t]; hd = exp_d[k][t]; end
            exp_a[k][t] = ha;
            exp_d[k][t] = hd;
        end
    endtask

    task automatic check_cycle(input int t);
        chk(p6 == exp_p[0][t], "R5 R6 R8 R9 R11 pulse n6", t, 48'(p6), 48'(exp_p[0][t]));
        chk(a6 == exp_a[0][t], "R2 R3 R7 R10 addr n6", t, 48'(a6), 48'(exp_a[0][t]));
        chk(d6 == exp_d[0][t], "R2 R7 R10 data n6", t, 48'(d6), 48'(exp_d[0][t]));
        chk(p3 == exp_p[1][t], "R5 R6 R8 R9 pulse n3", t, 48'(p3), 48'(exp_p[1][t]));
        chk(a3 == exp_a[1][t], "R3 R7 addr n3", t, 48'(a3), 48'(exp_a[1][t]));
        chk(d3 == exp_d[1][t], "R4 data n3 zero fill", t, 48'(d3), 48'(exp_d[1][t]));
    endtask

    initial begin
        int t;
        int dl[12] = '{6, 6, 1, 1, 1, 3, 2, 6, 7, 5, 4, 1};
        int di = 0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < T; i++) begin
            stb_a[i]  = 1'b0;
            rst_a[i]  = 1'b0;
            byte_a[i] = 8'($urandom);
        end
        t = 0;
        while (t < T - 20) begin
            int f = (di < 12) ? dl[di] : 1 + int'($urandom % 9);
            di++;
            stb_a[t] = 1'b1;
            if (f >= 2)
                byte_a[t+1] = {2'($urandom), ($urandom % 2 == 0) ? 6'h0A : 6'($urandom)};
            t += f;
        end
        for (int i = 0; i < T - 20; i++) stb_a[i] = (i < T - 20) ? stb_a[i] : 1'b0;
        for (int i = 0; i < 8; i++) begin
            int r = 100 + int'($urandom % (T - 140));
            if (!stb_a[r]) rst_a[r] = 1'b1;
        end
        fill_exp(0, 6, 14'h0A00, 14'h3F00);
        fill_exp(1, 3, 14'h0000, 14'h3000);

        // Reset held: a strobe during reset must start nothing (R1)
        repeat (2) @(negedge clk);
        bus_stb = 1'b1; bus_byte = 8'h55;
        @(negedge clk);
        bus_stb = 1'b0;
        @(negedge clk);
        chk(!p6 && a6 == 0 && d6 == 0, "R1 reset n6", -1, {p6, a6, d6[31:0]}, 48'h0);
        chk(!p3 && a3 == 0 && d3 == 0, "R1 reset n3", -1, {p3, a3, d3[31:0]}, 48'h0);

        for (int c = 0; c < T; c++) begin
            if (c > 0) @(negedge clk);
            check_cycle(c);
            rst      = rst_a[c];
            bus_stb  = stb_a[c];
            bus_byte = byte_a[c];
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule